// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where an instruction's operand lives and, when the operand sits in memory, fetches it. One computation is run per start pulse. It takes a 4-bit addressing-mode code, the instruction's address field, the program counter (already advanced past the instruction), an index register, a base register and the value of one general register that the surrounding decoder has selected. From these it produces the effective address and the operand value. When the mode calls for it, it also returns a new value to write back into the selected general register.

Memory is reached through a single read port with a request/ready handshake. The indirect mode uses two reads: a pointer read and then the operand read. Every other memory mode uses a single operand read. The modes that need no memory finish one cycle after the start pulse. The done output stays high, with the results held, until the next start pulse is accepted.

The sequencer has four states. ST_IDLE is the state after reset. ST_PTR_RD issues the pointer read of the indirect mode. ST_OPND_RD issues the final operand read. ST_FINISH holds the results and drives done.

The transitions are as follows:
- ST_IDLE or ST_FINISH goes to ST_PTR_RD on a start with the indirect mode.
- ST_IDLE or ST_FINISH goes to ST_OPND_RD on a start with any other memory mode.
- ST_IDLE or ST_FINISH goes to ST_FINISH on a start with a non-memory mode or an illegal code.
- ST_PTR_RD goes to ST_OPND_RD when ready is seen.
- ST_OPND_RD goes to ST_FINISH when ready is seen.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset the unit is in ST_IDLE, with done, mem_req, reg_we and illegal all low.
- R2: Mode codes are: 0 implied, 1 immediate, 2 register, 3 register indirect, 4 autoincrement, 5 autodecrement, 6 direct, 7 indirect, 8 PC-relative, 9 indexed and 10 base. For codes 11 to 15 the unit raises illegal, returns ea and operand as 0, performs no memory read and no register write, and asserts done.
- R3: Direct mode gives ea = addr field. PC-relative gives ea = pc + addr field, so 500 with a pc of 202 gives 702. Indexed gives ea = xr + addr field. Base gives ea = br + addr field. All sums wrap modulo 2^DW.
- R4: Register indirect gives ea = reg_val. Autoincrement gives ea = reg_val and writes back reg_val+1. Autodecrement gives ea = reg_val-1 (400 gives 399) and writes back that same value. Each writeback is one single-cycle reg_we pulse. No other mode writes back.
- R5: Indirect mode reads memory at the address field, and the returned word becomes ea. It then reads the operand at that word, so exactly two reads are made.
- R6: Every mode except implied, immediate and register ends with exactly one read at ea, and the returned data becomes the operand.
- R7: Implied mode gives operand 0, immediate gives operand = addr field, and register gives operand = reg_val. These three modes give ea 0, make no memory read and set done one cycle after start.
- R8: While mem_req is high and mem_ready is low, mem_req stays high and mem_addr stays stable in the next cycle.
- R9: done, with ea and operand held, stays high until the next start. A start while a read sequence is in progress is ignored.
- R10: done and mem_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation (accepted in ST_IDLE or ST_FINISH) |
| mode | input | 4 | Addressing-mode code |
| addr_fld | input | DW | Instruction address field |
| pc | input | DW | Program counter, already incremented |
| xr | input | DW | Index register |
| br | input | DW | Base register |
| reg_val | input | DW | Selected general register value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | DW | Memory read address |
| mem_ready | input | 1 | Read data valid / request taken |
| mem_rdata | input | DW | Read data |
| reg_we | output | 1 | Selected-register writeback strobe |
| reg_wdata | output | DW | Writeback value |
| done | output | 1 | Results valid |
| illegal | output | 1 | Mode code is unused |
| ea | output | DW | Effective address |
| operand | output | DW | Operand value |

## Verification
The checker watches several properties on every cycle. It checks that a pending request holds its address until ready, that done persists until a start arrives, and that done never overlaps a request. It also checks that a writeback strobe lasts one cycle and that an illegal code never reaches memory. The address arithmetic of each mode, the order and addresses of the two indirect reads, the wrap of the auto modes and the rejection of a start during a read sequence can only be shown by the directed scenarios. These scenarios compare ea, operand, read counts and writebacks with values the bench derives itself.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_IMPLIED  = 4'd0,
        AM_IMMED    = 4'd1,
        AM_REG      = 4'd2,
        AM_REGIND   = 4'd3,
        AM_AUTOINC  = 4'd4,
        AM_AUTODEC  = 4'd5,
        AM_DIRECT   = 4'd6,
        AM_INDIRECT = 4'd7,
        AM_RELATIVE = 4'd8,
        AM_INDEXED  = 4'd9,
        AM_BASE     = 4'd10
    } am_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PTR_RD,
        ST_OPND_RD,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic legal;
        logic needs_ptr;
        logic needs_opnd;
        logic reg_update;
    } mode_class_t;

endpackage

// File: rtl/addr_mode_dec.sv
module addr_mode_dec
    import addr_gen_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_class_t       cls
);

    always_comb begin
        cls = '0;
        unique case (mode)
            AM_IMPLIED, AM_IMMED, AM_REG: begin
                cls.legal = 1'b1;
            end
            AM_AUTOINC, AM_AUTODEC: begin
                cls.legal      = 1'b1;
                cls.needs_opnd = 1'b1;
                cls.reg_update = 1'b1;
            end
            AM_INDIRECT: begin
                cls.legal      = 1'b1;
                cls.needs_ptr  = 1'b1;
                cls.needs_opnd = 1'b1;
            end
            AM_REGIND, AM_DIRECT, AM_RELATIVE, AM_INDEXED, AM_BASE: begin
                cls.legal      = 1'b1;
                cls.needs_opnd = 1'b1;
            end
            default: cls = '0;
        endcase
    end

endmodule

// File: rtl/addr_ea_calc.sv
module addr_ea_calc
    import addr_gen_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     addr_fld,
    input  logic [DW-1:0]     pc,
    input  logic [DW-1:0]     xr,
    input  logic [DW-1:0]     br,
    input  logic [DW-1:0]     reg_val,
    output logic [DW-1:0]     ea_first,
    output logic [DW-1:0]     opnd_now,
    output logic [DW-1:0]     wb_val
);

    localparam logic [DW-1:0] ONE   = DW'(1);
    localparam logic [DW-1:0] M_ONE = {DW{1'b1}};

    logic [DW-1:0] base_sel;
    logic [DW-1:0] offs_sel;

    // one shared adder: base operand plus offset operand
    always_comb begin
        base_sel = '0;
        offs_sel = '0;
        opnd_now = '0;
        unique case (mode)
            AM_IMMED:    opnd_now = addr_fld;
            AM_REG:      opnd_now = reg_val;
            AM_REGIND,
            AM_AUTOINC:  base_sel = reg_val;
            AM_AUTODEC: begin
                base_sel = reg_val;
                offs_sel = M_ONE;
            end
            AM_DIRECT,
            AM_INDIRECT: offs_sel = addr_fld;
            AM_RELATIVE: begin
                base_sel = pc;
                offs_sel = addr_fld;
            end
            AM_INDEXED: begin
                base_sel = xr;
                offs_sel = addr_fld;
            end
            AM_BASE: begin
                base_sel = br;
                offs_sel = addr_fld;
            end
            default: begin
                base_sel = '0;
                offs_sel = '0;
            end
        endcase
    end

    assign ea_first = base_sel + offs_sel;
    assign wb_val   = (mode == AM_AUTOINC) ? reg_val + ONE : reg_val + M_ONE;

endmodule

// File: rtl/addr_seq_fsm.sv
module addr_seq_fsm
    import addr_gen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mode_class_t cls,
    input  logic        mem_ready,
    output logic        accept,
    output logic        ptr_ack,
    output logic        opnd_ack,
    output logic        mem_req,
    output logic        done
);

    seq_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_FINISH: begin
                if (start) begin
                    if (!cls.legal)         nxt = ST_FINISH;
                    else if (cls.needs_ptr) nxt = ST_PTR_RD;
                    else if (cls.needs_opnd) nxt = ST_OPND_RD;
                    else                    nxt = ST_FINISH;
                end
            end
            ST_PTR_RD:  if (mem_ready) nxt = ST_OPND_RD;
            ST_OPND_RD: if (mem_ready) nxt = ST_FINISH;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        ptr_ack  = 1'b0;
        opnd_ack = 1'b0;
        mem_req  = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:    accept = start;
            ST_FINISH: begin
                accept = start;
                done   = 1'b1;
            end
            ST_PTR_RD: begin
                mem_req = 1'b1;
                ptr_ack = mem_ready;
            end
            ST_OPND_RD: begin
                mem_req  = 1'b1;
                opnd_ack = mem_ready;
            end
            default: accept = 1'b0;
        endcase
    end

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
    import addr_gen_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     addr_fld,
    input  logic [DW-1:0]     pc,
    input  logic [DW-1:0]     xr,
    input  logic [DW-1:0]     br,
    input  logic [DW-1:0]     reg_val,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    input  logic              mem_ready,
    input  logic [DW-1:0]     mem_rdata,
    output logic              reg_we,
    output logic [DW-1:0]     reg_wdata,
    output logic              done,
    output logic              illegal,
    output logic [DW-1:0]     ea,
    output logic [DW-1:0]     operand
);

    mode_class_t   cls;
    logic [DW-1:0] ea_first, opnd_now, wb_val;
    logic          accept, ptr_ack, opnd_ack;

    logic [DW-1:0] ea_q, opnd_q, wdata_q;
    logic          we_q, illegal_q;

    addr_mode_dec u_dec (
        .mode (mode),
        .cls  (cls)
    );

    addr_ea_calc #(.DW(DW)) u_calc (
        .mode     (mode),
        .addr_fld (addr_fld),
        .pc       (pc),
        .xr       (xr),
        .br       (br),
        .reg_val  (reg_val),
        .ea_first (ea_first),
        .opnd_now (opnd_now),
        .wb_val   (wb_val)
    );

    addr_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cls       (cls),
        .mem_ready (mem_ready),
        .accept    (accept),
        .ptr_ack   (ptr_ack),
        .opnd_ack  (opnd_ack),
        .mem_req   (mem_req),
        .done      (done)
    );

    // result registers; ea_q doubles as the read address in both read states
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q      <= '0;
            opnd_q    <= '0;
            wdata_q   <= '0;
            we_q      <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (accept) begin
                ea_q      <= ea_first;
                opnd_q    <= opnd_now;
                illegal_q <= ~cls.legal;
                we_q      <= cls.reg_update;
                wdata_q   <= wb_val;
            end
            if (ptr_ack)  ea_q   <= mem_rdata;
            if (opnd_ack) opnd_q <= mem_rdata;
        end
    end

    assign mem_addr  = ea_q;
    assign ea        = ea_q;
    assign operand   = opnd_q;
    assign reg_we    = we_q;
    assign reg_wdata = wdata_q;
    assign illegal   = illegal_q;

endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          illegal,
    input logic          mem_req,
    input logic          mem_ready,
    input logic [DW-1:0] mem_addr,
    input logic          reg_we
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!done && !mem_req && !reg_we && !illegal));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R10
    done_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && mem_req));

    // R4
    wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R2
    illegal_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_req);

endmodule

bind addr_gen_unit addr_gen_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .illegal   (illegal),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .reg_we    (reg_we)
);

// File: tb/addr_gen_unit_tb.sv
module addr_gen_unit_tb;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [DW-1:0] addr_fld = '0, pc = '0, xr = '0, br = '0, reg_val = '0;
    logic          mem_req, mem_ready = 1'b0;
    logic [DW-1:0] mem_addr, mem_rdata;
    logic          reg_we, done, illegal;
    logic [DW-1:0] reg_wdata, ea, operand;

    int total = 0, bad = 0, cycles = 0;
    int lat = 0, wcnt = 0;
    int rd_cnt = 0, wb_cnt = 0;
    logic [DW-1:0] rd_addr0, rd_addr1, wb_last;

    always #4 clk = ~clk;

    addr_gen_unit #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_fld(addr_fld), .pc(pc), .xr(xr), .br(br), .reg_val(reg_val),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .done(done), .illegal(illegal), .ea(ea), .operand(operand)
    );

    function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
        return a * 16'd3 + 16'h0107;
    endfunction

    assign mem_rdata = memf(mem_addr);

    // memory responder with programmable wait
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) mem_ready = 1'b1;
            else wcnt++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (mem_req && mem_ready) begin
            if (rd_cnt == 0) rd_addr0 = mem_addr;
            if (rd_cnt == 1) rd_addr1 = mem_addr;
            rd_cnt++;
        end
        if (reg_we) begin
            wb_cnt++;
            wb_last = reg_wdata;
        end
    end

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // drive one computation, optionally poking start mid-sequence, then check
    task automatic run(input string tag, input logic [3:0] m, input logic [DW-1:0] af,
                       input logic [DW-1:0] pcv, input logic [DW-1:0] xv,
                       input logic [DW-1:0] bv, input logic [DW-1:0] rv,
                       input int l, input bit poke);
        logic [DW-1:0] e_ea, e_op, e_wb;
        int e_rd, e_wbn, n;
        bit seen;
        e_ea = '0; e_op = '0; e_wb = '0; e_rd = 1; e_wbn = 0;
        case (m)
            4'd0: e_rd = 0;
            4'd1: begin e_rd = 0; e_op = af; end
            4'd2: begin e_rd = 0; e_op = rv; end
            4'd3: e_ea = rv;
            4'd4: begin e_ea = rv; e_wbn = 1; e_wb = rv + 16'd1; end
            4'd5: begin e_ea = rv - 16'd1; e_wbn = 1; e_wb = rv - 16'd1; end
            4'd6: e_ea = af;
            4'd7: begin e_ea = memf(af); e_rd = 2; end
            4'd8: e_ea = pcv + af;
            4'd9: e_ea = xv + af;
            4'd10: e_ea = bv + af;
            default: e_rd = 0;
        endcase
        if (e_rd > 0) e_op = memf(e_ea);

        @(negedge clk);
        lat = l; rd_cnt = 0; wb_cnt = 0;
        mode = m; addr_fld = af; pc = pcv; xr = xv; br = bv; reg_val = rv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // start with a different mode while reads are pending: must be ignored (R9)
            mode = 4'd2; reg_val = 16'hDEAD; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        check({tag, " done reached"}, DW'(seen), DW'(1));
        check({tag, " ea"}, ea, e_ea);
        check({tag, " operand"}, operand, e_op);
        check({tag, " illegal"}, DW'(illegal), DW'(m > 4'd10));
        n = rd_cnt;
        check({tag, " read count"}, DW'(n), DW'(e_rd));
        n = wb_cnt;
        check({tag, " writeback count"}, DW'(n), DW'(e_wbn));
        if (e_wbn == 1) check({tag, " writeback value"}, wb_last, e_wb);
        if (e_rd == 2) begin
            check({tag, " first read addr R5"}, rd_addr0, af);
            check({tag, " second read addr R5"}, rd_addr1, memf(af));
        end
        if (e_rd == 1) check({tag, " read addr R6"}, rd_addr0, e_ea);
        repeat (3) @(negedge clk);
        check({tag, " done held R9"}, DW'(done), DW'(1));
        check({tag, " ea held R9"}, ea, e_ea);
    endtask

    task automatic t_reset;
        // R1
        check("R1 done", DW'(done), DW'(0));
        check("R1 mem_req", DW'(mem_req), DW'(0));
        check("R1 reg_we", DW'(reg_we), DW'(0));
        check("R1 illegal", DW'(illegal), DW'(0));
    endtask

    task automatic t_sum_modes;
        // R3 and R6
        run("R3 direct",   4'd6, 16'h1234, 16'd0, 16'd0, 16'd0, 16'd0, 0, 0);
        run("R3 relative", 4'd8, 16'd500, 16'd202, 16'd0, 16'd0, 16'd0, 1, 0);
        run("R3 indexed",  4'd9, 16'd500, 16'd0, 16'd100, 16'd0, 16'd0, 2, 0);
        run("R3 base",     4'd10, 16'h0010, 16'd0, 16'd0, 16'hFFF8, 16'd0, 0, 0);
        run("R3 relative wrap", 4'd8, 16'hFFFF, 16'h0002, 16'd0, 16'd0, 16'd0, 0, 0);
    endtask

    task automatic t_reg_modes;
        // R4
        run("R4 regind",      4'd3, 16'd0, 16'd0, 16'd0, 16'd0, 16'd400, 1, 0);
        run("R4 autoinc",     4'd4, 16'd0, 16'd0, 16'd0, 16'd0, 16'd400, 0, 0);
        run("R4 autoinc wrap", 4'd4, 16'd0, 16'd0, 16'd0, 16'd0, 16'hFFFF, 2, 0);
        run("R4 autodec",     4'd5, 16'd0, 16'd0, 16'd0, 16'd0, 16'd400, 0, 0);
        run("R4 autodec wrap", 4'd5, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 1, 0);
    endtask

    task automatic t_indirect;
        // R5
        run("R5 indirect",      4'd7, 16'd300, 16'd0, 16'd0, 16'd0, 16'd0, 0, 0);
        run("R5 indirect slow", 4'd7, 16'hABCD, 16'd0, 16'd0, 16'd0, 16'd0, 3, 0);
    endtask

    task automatic t_nomem;
        // R7
        run("R7 implied",   4'd0, 16'h5555, 16'd0, 16'd0, 16'd0, 16'h7777, 0, 0);
        run("R7 immediate", 4'd1, 16'h5555, 16'd0, 16'd0, 16'd0, 16'h7777, 0, 0);
        run("R7 register",  4'd2, 16'h5555, 16'd0, 16'd0, 16'd0, 16'h7777, 0, 0);
    endtask

    task automatic t_illegal;
        // R2
        for (int c = 11; c < 16; c++)
            run("R2 illegal code", 4'(c), 16'h4444, 16'd1, 16'd2, 16'd3, 16'd4, 0, 0);
        run("R2 legal after illegal", 4'd6, 16'h0042, 16'd0, 16'd0, 16'd0, 16'd0, 0, 0);
    endtask

    task automatic t_busy_start;
        // R9
        run("R9 start ignored while busy", 4'd7, 16'd77, 16'd0, 16'd0, 16'd0, 16'd0, 4, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sum_modes();
        t_reg_modes();
        t_indirect();
        t_nomem();
        t_illegal();
        t_busy_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule